// File: doc/BRIEF.md
# Interruptible Instruction Cache Reloader

This block is a direct-mapped instruction cache with a reload engine. Each cache line holds four instruction words, one address tag and four valid bits, one for each word. A line can therefore be partly filled. A fetch hits only when the stored tag matches and the valid bit of the addressed word is set. The hit is reported in the same cycle as the request.

On a miss the engine refills the line one word at a time over a simple memory read port. The word the core asked for is always read first. After it, the engine steps through the other word offsets of the line in ascending order, wrapping modulo four, and skips words that are already valid. A pending data access (a load or store wanting the bus) takes priority. While it is asserted, no new word request is issued and a reload in progress is abandoned once its outstanding word returns. The words already fetched remain valid. A later miss on the same line fetches only the words still missing. A cache-wide flush input clears every valid bit.

The full-size cache is 8 KB. The depth here is a parameter (`SETS`), and the default is scaled down for verification. Addresses are word addresses, split as {tag, set index, word offset[1:0]}.

Top module: `icache_reloader`

## Requirements
- R1: When `fetch_req` is high, the stored tag of set `fetch_addr[IDX_W+1:2]` equals `fetch_addr[ADDR_W-1:IDX_W+2]`, and the valid bit of word `fetch_addr[1:0]` is set, `fetch_hit` is high in the same cycle and `fetch_rdata` equals the word memory returned for that address.
- R2: A fetch whose tag differs from the stored tag, or whose word valid bit is clear, gives `fetch_hit` low.
- R3: The first memory request after a miss carries the missed word address itself, not word 0 of the line.
- R4: Within one reload, requests follow the offsets target, target+1, target+2, target+3 (modulo 4). Only one request is outstanding at a time, and `mem_req` is never high in two consecutive cycles.
- R5: A miss to a set holding a different tag stores the new tag and clears all four valid bits of that set before any word is refilled. The old words then miss.
- R6: While `dmem_pending` is high, `mem_req` stays low. A reload that sees it stops after its outstanding word. Fetched words stay valid and the unfetched words stay invalid.
- R7: A miss on an invalid word of a line whose tag matches refills only the invalid words, starting at the requested one. No request is made for a word that is already valid.
- R8: `flush_all` clears every valid bit, so no fetch hits in the following cycle. A word that is outstanding during the flush is discarded when it returns.
- R9: During reset all valid bits are clear, `fetch_hit` is low and `mem_req` is low.
- R10: No reload starts while `dmem_pending` is high. A missing fetch waits and is served after the pending access goes away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_all | input | 1 | Clears all valid bits |
| fetch_req | input | 1 | Instruction fetch request |
| fetch_addr | input | ADDR_W | Fetch word address {tag, set, offset} |
| fetch_hit | output | 1 | Fetch hit, same cycle |
| fetch_rdata | output | DATA_W | Instruction word on a hit |
| dmem_pending | input | 1 | Higher-priority data access pending; preempts reload |
| mem_req | output | 1 | One-cycle word read request |
| mem_addr | output | ADDR_W | Word address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |

## Verification
The hardest state to reach from the ports is a partly valid line whose tag still matches. Reaching it needs a data access that arrives exactly between two word requests of a reload. The bench waits until the memory model has logged the first request of a reload. It then raises the data-access input at the next falling edge, so the outstanding word lands but the next request is blocked. From there it probes every word of the line and releases the preempt. It then checks that the resumed refill asks only for the missing offsets, in wrap order. Random fetches with random preempts and rare flushes follow, and every hit is compared against the memory contents.

// File: rtl/icache_reloader.sv
module icache_reloader #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SETS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_all,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_hit,
  output logic [DATA_W-1:0] fetch_rdata,
  input  logic              dmem_pending,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - 2 - IDX_W;
  localparam int LINES = SETS * 4;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_t;

  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [3:0]        vld_q  [SETS];
  logic [DATA_W-1:0] data_q [LINES];

  state_t            st;
  logic              squash_q;
  logic [TAG_W-1:0]  f_tag;
  logic [IDX_W-1:0]  f_set;
  logic [1:0]        f_off, f_start;

  logic [TAG_W-1:0]  in_tag;
  logic [IDX_W-1:0]  in_set;
  logic [1:0]        in_off;
  logic              tag_match, start_miss, accept;
  logic [3:0]        vld_now;
  logic [1:0]        nxt_off;
  logic              nxt_found;

  assign {in_tag, in_set, in_off} = fetch_addr;
  assign tag_match   = (tag_q[in_set] == in_tag);
  assign fetch_hit   = fetch_req && tag_match && vld_q[in_set][in_off];
  assign fetch_rdata = data_q[{in_set, in_off}];

  assign start_miss = (st == S_IDLE) && fetch_req && !fetch_hit && !dmem_pending && !flush_all;
  assign mem_req    = (st == S_ISSUE) && !dmem_pending && !flush_all;
  assign mem_addr   = {f_tag, f_set, f_off};
  assign accept     = (st == S_WAIT) && mem_rvalid && !squash_q && !flush_all;

  always_comb begin
    logic [1:0] cand;
    logic       stop;
    vld_now        = vld_q[f_set];
    vld_now[f_off] = 1'b1;
    nxt_off        = f_off;
    nxt_found      = 1'b0;
    stop           = 1'b0;
    for (int k = 1; k < 4; k++) begin
      cand = f_off + 2'(k);
      if (cand == f_start) stop = 1'b1;
      if (!stop && !nxt_found && !vld_now[cand]) begin
        nxt_found = 1'b1;
        nxt_off   = cand;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      squash_q <= 1'b0;
      f_tag    <= '0;
      f_set    <= '0;
      f_off    <= '0;
      f_start  <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (start_miss) begin
            st      <= S_ISSUE;
            f_tag   <= in_tag;
            f_set   <= in_set;
            f_off   <= in_off;
            f_start <= in_off;
          end
        S_ISSUE:
          st <= (dmem_pending || flush_all) ? S_IDLE : S_WAIT;
        S_WAIT: begin
          if (flush_all) squash_q <= 1'b1;
          if (mem_rvalid) begin
            squash_q <= 1'b0;
            if (accept && nxt_found) begin
              st    <= S_ISSUE;
              f_off <= nxt_off;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) vld_q[i] <= '0;
    end else if (flush_all) begin
      for (int i = 0; i < SETS; i++) vld_q[i] <= '0;
    end else if (start_miss && !tag_match) begin
      vld_q[in_set] <= '0;
    end else if (accept) begin
      vld_q[f_set][f_off] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (start_miss && !tag_match) tag_q[in_set] <= in_tag;
    if (accept) data_q[{f_set, f_off}] <= mem_rdata;
  end

  assert_first_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_miss |=> (mem_addr == $past(fetch_addr)));

  assert_single_outstanding_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  assert_new_tag_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_miss && !tag_match && !flush_all) |=> (vld_q[$past(in_set)] == 4'b0000));

  assert_preempt_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_ISSUE) && dmem_pending) |=> (st == S_IDLE));

  assert_no_redundant_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !vld_q[f_set][f_off]);

  assert_flush_no_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !fetch_hit);
endmodule

// File: tb/test_icache_reloader.sv
module test_icache_reloader;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 12;
  localparam int DW   = 32;
  localparam int SETS = 16;

  logic          clk = 1'b0;
  logic          rst_n, flush_all, fetch_req, dmem_pending;
  logic [AW-1:0] fetch_addr;
  logic          fetch_hit;
  logic [DW-1:0] fetch_rdata;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_rvalid;
  logic [DW-1:0] mem_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  icache_reloader #(.ADDR_W(AW), .DATA_W(DW), .SETS(SETS)) i_icache_reloader (
    .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_hit(fetch_hit), .fetch_rdata(fetch_rdata),
    .dmem_pending(dmem_pending),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit rnd_on = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic logic [31:0] memval(input logic [AW-1:0] a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A1234;
  endfunction

  function automatic logic [AW-1:0] mk(input int tag, input int set, input int off);
    return {6'(tag), 4'(set), 2'(off)};
  endfunction

  // memory model: samples requests after inputs settle
  logic [AW-1:0] rlog [256];
  int            nlog = 0;
  initial begin
    bit            pend;
    int            lat;
    logic [AW-1:0] paddr;
    pend = 1'b0; lat = 0; paddr = '0;
    mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk); #1;
      mem_rvalid = 1'b0;
      if (pend) begin
        lat--;
        if (lat == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = memval(paddr);
          pend       = 1'b0;
        end
      end
      if (rst_n && mem_req) begin
        pend  = 1'b1;
        paddr = mem_addr;
        lat   = 1 + int'($urandom % 3);
        rlog[nlog % 256] = mem_addr;
        nlog++;
      end
    end
  end

  // monitor: every hit returns memory contents; no request under preempt
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n && fetch_hit) chk(fetch_rdata == memval(fetch_addr), "R1 hit data", fetch_rdata, memval(fetch_addr));
      if (rst_n && dmem_pending) chk(!mem_req, "R6 request under preempt", 32'(mem_req), 0);
    end
  end

  // random preempt / flush driver
  initial begin
    forever begin
      @(negedge clk);
      if (rnd_on) begin
        dmem_pending = ($urandom % 4) == 0;
        flush_all    = ($urandom % 60) == 0;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    finish_run();
  end

  task automatic probe(input logic [AW-1:0] a, output bit h);
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = a;
    #2 h = fetch_hit;
    #1 fetch_req = 1'b0;
  endtask

  task automatic fetch_wait(input logic [AW-1:0] a, input int maxc, output bit h);
    h = 1'b0;
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = a;
    for (int i = 0; i < maxc; i++) begin
      #2;
      if (fetch_hit) begin h = 1'b1; break; end
      @(negedge clk);
    end
    @(negedge clk);
    fetch_req = 1'b0;
  endtask

  task automatic wait_req(input int n);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #2;
      if (nlog >= n) break;
    end
  endtask

  initial begin
    bit h;
    int n0;
    void'($urandom(32'd2024));
    rst_n = 1'b0; flush_all = 1'b0; fetch_req = 1'b0; dmem_pending = 1'b0; fetch_addr = '0;
    repeat (3) @(negedge clk);
    fetch_req = 1'b1; fetch_addr = mk(1, 3, 2);
    #2;
    chk(!mem_req, "R9 mem_req in reset", 32'(mem_req), 0);
    chk(!fetch_hit, "R9 hit in reset", 32'(fetch_hit), 0);
    @(negedge clk);
    fetch_req = 1'b0; rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // critical word first, wrap order
    n0 = nlog;
    fetch_wait(mk(1, 3, 2), 60, h);
    chk(h, "R3 miss served", 32'(h), 1);
    wait_req(n0 + 4);
    repeat (6) @(negedge clk);
    #2;
    chk(nlog == n0 + 4, "R4 request count", nlog - n0, 4);
    chk(rlog[n0 % 256] == mk(1, 3, 2), "R3 first word", 32'(rlog[n0 % 256]), 32'(mk(1, 3, 2)));
    for (int k = 1; k < 4; k++)
      chk(rlog[(n0 + k) % 256] == mk(1, 3, (2 + k) % 4), "R4 wrap order", 32'(rlog[(n0 + k) % 256]), 32'(mk(1, 3, (2 + k) % 4)));
    for (int w = 0; w < 4; w++) begin
      probe(mk(1, 3, w), h);
      chk(h, "R1 full line hit", 32'(h), 1);
    end
    probe(mk(2, 3, 0), h);
    chk(!h, "R2 tag mismatch", 32'(h), 0);
    probe(mk(1, 4, 0), h);
    chk(!h, "R2 invalid set", 32'(h), 0);

    // preempt after first word
    n0 = nlog;
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = mk(1, 5, 1);
    wait_req(n0 + 1);
    @(negedge clk);
    dmem_pending = 1'b1; fetch_req = 1'b0;
    repeat (8) @(negedge clk);
    #2;
    chk(nlog == n0 + 1, "R6 reload stopped", nlog - n0, 1);
    probe(mk(1, 5, 1), h);
    chk(h, "R6 fetched word kept", 32'(h), 1);
    for (int w = 2; w < 5; w++) begin
      probe(mk(1, 5, w % 4), h);
      chk(!h, "R6 unfetched word invalid", 32'(h), 0);
    end
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = mk(1, 5, 2);
    repeat (5) @(negedge clk);
    #2;
    chk(nlog == n0 + 1, "R10 no start under preempt", nlog - n0, 1);
    chk(!fetch_hit, "R10 miss held", 32'(fetch_hit), 0);
    @(negedge clk);
    dmem_pending = 1'b0;
    fetch_wait(mk(1, 5, 2), 60, h);
    chk(h, "R10 served after preempt", 32'(h), 1);
    wait_req(n0 + 4);
    repeat (6) @(negedge clk);
    #2;
    chk(nlog == n0 + 4, "R7 only missing words", nlog - n0, 4);
    for (int k = 0; k < 3; k++)
      chk(rlog[(n0 + 1 + k) % 256] == mk(1, 5, (2 + k) % 4), "R7 resume order", 32'(rlog[(n0 + 1 + k) % 256]), 32'(mk(1, 5, (2 + k) % 4)));

    // tag replacement clears old words
    n0 = nlog;
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = mk(2, 3, 0);
    wait_req(n0 + 1);
    @(negedge clk);
    dmem_pending = 1'b1; fetch_req = 1'b0;
    repeat (6) @(negedge clk);
    chk(rlog[n0 % 256] == mk(2, 3, 0), "R3 replace first word", 32'(rlog[n0 % 256]), 32'(mk(2, 3, 0)));
    probe(mk(2, 3, 0), h);
    chk(h, "R5 new word hit", 32'(h), 1);
    probe(mk(1, 3, 1), h);
    chk(!h, "R5 old word cleared", 32'(h), 0);
    probe(mk(2, 3, 2), h);
    chk(!h, "R5 new tag other word invalid", 32'(h), 0);
    @(negedge clk);
    dmem_pending = 1'b0;

    // flush while idle
    n0 = nlog;
    fetch_wait(mk(3, 7, 0), 60, h);
    wait_req(n0 + 4);
    repeat (6) @(negedge clk);
    probe(mk(3, 7, 3), h);
    chk(h, "R1 line before flush", 32'(h), 1);
    @(negedge clk); flush_all = 1'b1;
    @(negedge clk); flush_all = 1'b0;
    fetch_req = 1'b1; fetch_addr = mk(3, 7, 3);
    #2 chk(!fetch_hit, "R8 hit after flush", 32'(fetch_hit), 0);
    #1 fetch_req = 1'b0;
    probe(mk(1, 5, 1), h);
    chk(!h, "R8 other set cleared", 32'(h), 0);

    // flush while a word is outstanding
    n0 = nlog;
    @(negedge clk);
    fetch_req = 1'b1; fetch_addr = mk(3, 8, 1);
    wait_req(n0 + 1);
    @(negedge clk);
    fetch_req = 1'b0; flush_all = 1'b1; dmem_pending = 1'b1;
    @(negedge clk);
    flush_all = 1'b0;
    repeat (6) @(negedge clk);
    probe(mk(3, 8, 1), h);
    chk(!h, "R8 outstanding word discarded", 32'(h), 0);
    chk(nlog == n0 + 1, "R8 no further request", nlog - n0, 1);
    @(negedge clk);
    dmem_pending = 1'b0;

    // random phase
    rnd_on = 1'b1;
    for (int it = 0; it < 300; it++) begin
      logic [AW-1:0] a;
      a = mk(int'($urandom % 3), int'($urandom % 4), int'($urandom % 4));
      fetch_wait(a, 150, h);
      chk(h, "R1 random fetch served", 32'(h), 1);
    end
    rnd_on = 1'b0;
    @(negedge clk);
    dmem_pending = 1'b0; flush_all = 1'b0;
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule